// File: doc/BRIEF.md
# Consumer Digital Audio Serial Transmitter

This block turns a stream of stereo audio words into a single self-clocking serial line of the consumer digital audio interface type. Each stereo frame is sent as two subframes, left then right. A subframe opens with a synchronisation preamble and then carries a 24-slot audio field. After the audio field come a validity flag, one user-data bit, one channel-status bit and an even-parity bit. Every slot is biphase-mark coded. The clock runs at one half-cell per cycle, so it must be 128 times the sample rate.

The audio field is filled from one of two sources. One is a 20-bit processed PCM sample. The other is a raw 16-bit coded word taken straight from a serial input. Five channel-status bytes come from a configuration vector, and every later status bit in a 192-frame block is zero. User data is streamed from an internal 129-byte message buffer, one bit per subframe. This buffer is written through a simple byte write port. Until the first write, every user bit is zero. Clearing the enable places the line in high impedance and restarts the framing.

Top module: `spdif_tx`

## Requirements
- R1: While `txEnable` is low, `spdifOut` is 0 from the next cycle on. All framing counters restart. After a re-enable, the first subframe is the opening subframe of a new block (frame 0, user bit index 0), sent from a low line.
- R2: A subframe is 64 half-cells, one per clock, forming 32 slots. Slots 0-3 are the preamble. Slots 4-27 carry the audio field, LSB first. Slot 28 is validity, slot 29 is user, slot 30 is channel status and slot 31 is parity. The left subframe is sent first.
- R3: Preambles are given here as line levels from a low line; each is inverted when the line was high. The left subframe of frame 0 of each 192-frame block uses 1,1,1,0,1,0,0,0. Other left subframes use 1,1,1,0,0,0,1,0. Right subframes use 1,1,1,0,0,1,0,0.
- R4: Each of slots 4-31 starts with a line transition, and it has a second transition in mid-slot exactly when its bit is 1.
- R5: Slots 4-31 of every subframe hold an even number of ones, so the line is low at the end of each subframe.
- R6: With `bypassSel` = 0, the 20-bit PCM sample fills audio bits 4-23, and audio bits 0-3 are zero. Each input is captured during the last preamble half-cell of its subframe.
- R7: With `bypassSel` = 1, the 16-bit raw word fills audio bits 8-23, and audio bits 0-7 are zero.
- R8: The validity slot carries `validFlag`.
- R9: In frame n of a block (0-191), both subframes carry bit n%8 of status byte n/8. Byte k is `csBytes[8k+7:8k]`, sent LSB first. In byte 0 these bits pass unchanged: bit 0 consumer, bit 1 linear PCM, bit 2 copy, bits 3-5 pre-emphasis, bits 6-7 mode. Bytes 5-23 are zero.
- R10: Subframe number m since enable (m = 2·frame + right) carries bit m%8 of buffer byte (m/8)%129, so the buffer repeats every 516 frames.
- R11: All user bits are zero until a buffer byte has been written after reset. Buffer contents and the written state survive a disable.
- R12: `spdifOe` is 1 in each cycle that follows a cycle with `txEnable` high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 x sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmitter enable; low resets framing and floats the line |
| bypassSel | input | 1 | 1 selects the raw coded word as payload |
| validFlag | input | 1 | Value sent in the validity slot |
| csBytes | input | 40 | Channel-status bytes 0-4, byte k at bits 8k+7:8k |
| pcmLeft | input | 20 | Processed left sample |
| pcmRight | input | 20 | Processed right sample |
| rawLeft | input | 16 | Raw coded left word |
| rawRight | input | 16 | Raw coded right word |
| usrWrEn | input | 1 | User buffer write strobe |
| usrWrAddr | input | 8 | User buffer byte address (0-128) |
| usrWrData | input | 8 | User buffer write data |
| spdifOut | output | 1 | Biphase-mark coded line level |
| spdifOe | output | 1 | Line driver enable (0 = high impedance) |

## Verification
Several properties are checked on every cycle. The line must change at the start of every data slot, and it must be low after the last half-cell of each subframe. The line must be quiet, and the driver off, one cycle after the enable drops. The frame counter must wrap to zero after frame 191. The actual field contents can only be shown by the bench decoding the line. These are the preamble choice at block and subframe boundaries, PCM against bypass payload placement, status bits against the five configured bytes, and user bits, both before the buffer is written and across the 516-frame wrap.

// File: rtl/spdif_pkg.sv
package spdif_pkg;

  localparam int HALVES_PER_SUB = 64;

  // toggle masks for preamble half-cells, bit i = toggle in half i
  localparam logic [7:0] PRE_BLOCK_TOG = 8'b0011_1001;
  localparam logic [7:0] PRE_LEFT_TOG  = 8'b1100_1001;
  localparam logic [7:0] PRE_RIGHT_TOG = 8'b0110_1001;

  typedef struct packed {
    logic loadWord;
    logic preamble;
    logic preToggle;
    logic dataSlot;
    logic paritySlot;
    logic firstHalf;
    logic rightSub;
    logic csBit;
  } ctrlStrobes_t;

endpackage

// File: rtl/spdif_ctrl.sv
module spdif_ctrl
  import spdif_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int CS_BYTES     = 5,
  parameter int MSG_BYTES    = 129,
  localparam int FRAME_W = $clog2(BLOCK_FRAMES),
  localparam int MSG_BITS = MSG_BYTES * 8,
  localparam int UIDX_W  = $clog2(MSG_BITS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  txEnable,
  input  logic [CS_BYTES*8-1:0] csBytes,
  output ctrlStrobes_t          strobes,
  output logic [UIDX_W-1:0]     usrIdx,
  output logic [6:0]            halfPos,
  output logic [FRAME_W-1:0]    frameIdx
);

  localparam int CS_BITS = CS_BYTES * 8;
  localparam int CSIDX_W = $clog2(CS_BITS);

  logic [6:0]         halfCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic [UIDX_W-1:0]  usrCnt;
  logic [4:0]         slot;
  logic [7:0]         prePat;
  logic [CSIDX_W-1:0] csIdx;
  logic               csSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt  <= '0;
      frameCnt <= '0;
      usrCnt   <= '0;
    end else if (!txEnable) begin
      halfCnt  <= '0;
      frameCnt <= '0;
      usrCnt   <= '0;
    end else begin
      halfCnt <= halfCnt + 7'd1;
      if (halfCnt == 7'd127)
        frameCnt <= (frameCnt == FRAME_W'(BLOCK_FRAMES - 1)) ? '0 : frameCnt + FRAME_W'(1);
      if (halfCnt[5:0] == 6'd63)
        usrCnt <= (usrCnt == UIDX_W'(MSG_BITS - 1)) ? '0 : usrCnt + UIDX_W'(1);
    end
  end

  assign slot = halfCnt[5:1];

  always_comb begin
    if (halfCnt[6])            prePat = PRE_RIGHT_TOG;
    else if (frameCnt == '0)   prePat = PRE_BLOCK_TOG;
    else                       prePat = PRE_LEFT_TOG;
  end

  assign csIdx = CSIDX_W'(frameCnt);

  always_comb begin
    csSel = 1'b0;
    if (frameCnt < FRAME_W'(CS_BITS)) csSel = csBytes[csIdx];
  end

  always_comb begin
    strobes.loadWord   = (halfCnt[5:0] == 6'd7);
    strobes.preamble   = (halfCnt[5:3] == 3'd0);
    strobes.preToggle  = prePat[halfCnt[2:0]];
    strobes.dataSlot   = (slot >= 5'd4) && (slot != 5'd31);
    strobes.paritySlot = (slot == 5'd31);
    strobes.firstHalf  = ~halfCnt[0];
    strobes.rightSub   = halfCnt[6];
    strobes.csBit      = csSel;
  end

  assign usrIdx   = usrCnt;
  assign halfPos  = halfCnt;
  assign frameIdx = frameCnt;

endmodule

// File: rtl/spdif_dp.sv
module spdif_dp
  import spdif_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int RAW_W     = 16,
  parameter int AUDIO_W   = 24,
  parameter int MSG_BYTES = 129,
  localparam int ADDR_W = $clog2(MSG_BYTES),
  localparam int UIDX_W = ADDR_W + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic                bypassSel,
  input  logic                validFlag,
  input  logic [SAMPLE_W-1:0] pcmLeft,
  input  logic [SAMPLE_W-1:0] pcmRight,
  input  logic [RAW_W-1:0]    rawLeft,
  input  logic [RAW_W-1:0]    rawRight,
  input  logic                usrWrEn,
  input  logic [ADDR_W-1:0]   usrWrAddr,
  input  logic [7:0]          usrWrData,
  input  ctrlStrobes_t        strobes,
  input  logic [UIDX_W-1:0]   usrIdx,
  output logic                spdifOut,
  output logic                spdifOe
);

  localparam int WORD_W = AUDIO_W + 3;

  logic [7:0]         msgMem [MSG_BYTES];
  logic               msgLoaded;
  logic [WORD_W-1:0]  shiftWord;
  logic               parAcc;
  logic               lineLvl;
  logic               toggle;
  logic               usrBit;
  logic [AUDIO_W-1:0] payload;
  logic [7:0]         msgByte;

  always_ff @(posedge clk) begin
    if (usrWrEn && ({1'b0, usrWrAddr} < (ADDR_W + 1)'(MSG_BYTES)))
      msgMem[usrWrAddr] <= usrWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        msgLoaded <= 1'b0;
    else if (usrWrEn) msgLoaded <= 1'b1;
  end

  assign msgByte = msgMem[usrIdx[UIDX_W-1:3]];
  assign usrBit  = msgLoaded & msgByte[usrIdx[2:0]];

  always_comb begin
    if (bypassSel)
      payload = {strobes.rightSub ? rawRight : rawLeft, {(AUDIO_W - RAW_W){1'b0}}};
    else
      payload = {strobes.rightSub ? pcmRight : pcmLeft, {(AUDIO_W - SAMPLE_W){1'b0}}};
  end

  always_comb begin
    if (strobes.preamble)        toggle = strobes.preToggle;
    else if (strobes.firstHalf)  toggle = 1'b1;
    else if (strobes.paritySlot) toggle = parAcc;
    else                         toggle = shiftWord[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      parAcc    <= 1'b0;
      lineLvl   <= 1'b0;
      spdifOe   <= 1'b0;
    end else if (!txEnable) begin
      shiftWord <= '0;
      parAcc    <= 1'b0;
      lineLvl   <= 1'b0;
      spdifOe   <= 1'b0;
    end else begin
      spdifOe <= 1'b1;
      lineLvl <= lineLvl ^ toggle;
      if (strobes.loadWord) begin
        shiftWord <= {strobes.csBit, usrBit, validFlag, payload};
        parAcc    <= 1'b0;
      end else if (strobes.dataSlot && !strobes.firstHalf) begin
        shiftWord <= shiftWord >> 1;
        parAcc    <= parAcc ^ shiftWord[0];
      end
    end
  end

  assign spdifOut = lineLvl;

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_pkg::*;
#(
  parameter int SAMPLE_W     = 20,
  parameter int RAW_W        = 16,
  parameter int CS_BYTES     = 5,
  parameter int MSG_BYTES    = 129,
  parameter int BLOCK_FRAMES = 192,
  localparam int ADDR_W  = $clog2(MSG_BYTES),
  localparam int FRAME_W = $clog2(BLOCK_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  txEnable,
  input  logic                  bypassSel,
  input  logic                  validFlag,
  input  logic [CS_BYTES*8-1:0] csBytes,
  input  logic [SAMPLE_W-1:0]   pcmLeft,
  input  logic [SAMPLE_W-1:0]   pcmRight,
  input  logic [RAW_W-1:0]      rawLeft,
  input  logic [RAW_W-1:0]      rawRight,
  input  logic                  usrWrEn,
  input  logic [ADDR_W-1:0]     usrWrAddr,
  input  logic [7:0]            usrWrData,
  output logic                  spdifOut,
  output logic                  spdifOe
);

  ctrlStrobes_t        strobes;
  logic [ADDR_W+2:0]   usrIdx;
  logic [6:0]          halfPos;
  logic [FRAME_W-1:0]  frameIdx;

  spdif_ctrl #(
    .BLOCK_FRAMES(BLOCK_FRAMES), .CS_BYTES(CS_BYTES), .MSG_BYTES(MSG_BYTES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .csBytes(csBytes),
    .strobes(strobes), .usrIdx(usrIdx), .halfPos(halfPos), .frameIdx(frameIdx)
  );

  spdif_dp #(
    .SAMPLE_W(SAMPLE_W), .RAW_W(RAW_W), .AUDIO_W(24), .MSG_BYTES(MSG_BYTES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .bypassSel(bypassSel),
    .validFlag(validFlag), .pcmLeft(pcmLeft), .pcmRight(pcmRight),
    .rawLeft(rawLeft), .rawRight(rawRight), .usrWrEn(usrWrEn),
    .usrWrAddr(usrWrAddr), .usrWrData(usrWrData), .strobes(strobes),
    .usrIdx(usrIdx), .spdifOut(spdifOut), .spdifOe(spdifOe)
  );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int BLOCK_FRAMES = 192,
  localparam int FRAME_W = $clog2(BLOCK_FRAMES)
) (
  input logic               clk,
  input logic               rstN,
  input logic               txEnable,
  input logic               spdifOut,
  input logic               spdifOe,
  input logic [6:0]         halfPos,
  input logic [FRAME_W-1:0] frameIdx
);

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (!spdifOut && !spdifOe)); // R1

  AST_OE_WHEN_ON: assert property (@(posedge clk) disable iff (!rstN)
    txEnable |=> spdifOe); // R12

  AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !halfPos[0] && halfPos[5:1] >= 5'd4) |=> (spdifOut != $past(spdifOut))); // R4

  AST_SUB_ENDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && halfPos[5:0] == 6'd63) |=> !spdifOut); // R5

  AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && halfPos == 7'd127 && frameIdx == FRAME_W'(BLOCK_FRAMES - 1)) |=> frameIdx == '0); // R3

endmodule

bind spdif_tx spdif_tx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .spdifOut(spdifOut),
  .spdifOe(spdifOe), .halfPos(halfPos), .frameIdx(frameIdx)
);

// File: tb/test_spdif_tx.sv
`timescale 1ns/1ps
module test_spdif_tx;

  logic        clk = 1'b0;
  logic        rstN;
  logic        txEnable, bypassSel, validFlag;
  logic [39:0] csBytes;
  logic [19:0] pcmLeft, pcmRight;
  logic [15:0] rawLeft, rawRight;
  logic        usrWrEn;
  logic [7:0]  usrWrAddr, usrWrData;
  logic        spdifOut, spdifOe;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;
  bit  msgModel = 0;
  logic [7:0]  msg [129];
  logic [63:0] sfBuf;
  logic        prevLvl;

  always #2.5 clk = ~clk;

  spdif_tx i_spdif_tx (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .bypassSel(bypassSel),
    .validFlag(validFlag), .csBytes(csBytes), .pcmLeft(pcmLeft), .pcmRight(pcmRight),
    .rawLeft(rawLeft), .rawRight(rawRight), .usrWrEn(usrWrEn), .usrWrAddr(usrWrAddr),
    .usrWrData(usrWrData), .spdifOut(spdifOut), .spdifOe(spdifOe)
  );

  function automatic logic [19:0] pcmL(int k);
    logic [31:0] v = k; return 20'((v * 32'd40503 + 32'd1234) ^ (v << 7));
  endfunction
  function automatic logic [19:0] pcmR(int k);
    logic [31:0] v = k; return 20'((v * 32'd9973) ^ 32'hABCDE);
  endfunction
  function automatic logic [15:0] rawL(int k);
    logic [31:0] v = k; return 16'(v * 32'd1721 + 32'd99);
  endfunction
  function automatic logic [15:0] rawR(int k);
    logic [31:0] v = k; return 16'(~(v * 32'd313));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  task automatic setInputs(int fr);
    pcmLeft = pcmL(fr); pcmRight = pcmR(fr);
    rawLeft = rawL(fr); rawRight = rawR(fr);
  endtask

  task automatic checkSub(int fr, bit rt);
    logic [7:0]  pre, expPre;
    logic [27:0] bits;
    logic [23:0] expAudio;
    bit          edgeOk = 1;
    int          blk = fr % 192;
    int          ui = (2 * fr + (rt ? 1 : 0)) % 1032;
    logic        expC, expU;
    for (int i = 0; i < 8; i++) pre[i] = sfBuf[i];
    if (rt)            expPre = 8'b0010_0111;
    else if (blk == 0) expPre = 8'b0001_0111;
    else               expPre = 8'b0100_0111;
    if (prevLvl) expPre = ~expPre;
    chk(pre == expPre, "R3 preamble", {24'd0, pre}, {24'd0, expPre});
    for (int k = 4; k < 32; k++) begin
      if (sfBuf[2*k] == sfBuf[2*k-1]) edgeOk = 0;
      bits[k-4] = sfBuf[2*k] ^ sfBuf[2*k+1];
    end
    chk(edgeOk, "R4 cell edge", {31'd0, edgeOk}, 32'd1);
    chk(($countones(bits) % 2) == 0 && !sfBuf[63], "R5 parity", {4'd0, bits}, {31'd0, sfBuf[63]});
    if (bypassSel) expAudio = {rt ? rawR(fr) : rawL(fr), 8'd0};      // R7
    else           expAudio = {rt ? pcmR(fr) : pcmL(fr), 4'd0};      // R6
    chk(bits[23:0] == expAudio, bypassSel ? "R7 raw payload" : "R6 pcm payload",
        {8'd0, bits[23:0]}, {8'd0, expAudio});
    chk(bits[24] == validFlag, "R8 validity", {31'd0, bits[24]}, {31'd0, validFlag});
    expU = msgModel ? msg[ui / 8][ui % 8] : 1'b0;
    chk(bits[25] == expU, msgModel ? "R10 user bit" : "R11 user zero", {31'd0, bits[25]}, {31'd0, expU});
    expC = (blk < 40) ? csBytes[blk] : 1'b0;
    chk(bits[26] == expC, "R9 status bit", {31'd0, bits[26]}, {31'd0, expC});
    chk(spdifOe == 1'b1, "R12 oe on", {31'd0, spdifOe}, 32'd1);
  endtask

  // R1 R2: runs from a fresh enable; the line is decoded in 64-half subframes
  task automatic runHalves(int halves);
    setInputs(0);
    prevLvl = 1'b0;
    @(negedge clk);
    txEnable = 1'b1;
    for (int s = 0; s < halves; s++) begin
      @(negedge clk);
      sfBuf[s % 64] = spdifOut;
      if (s % 64 == 63) begin
        checkSub(s / 128, ((s / 64) % 2) == 1);
        prevLvl = sfBuf[63];
      end
      if (s % 128 == 100) setInputs(s / 128 + 1);
    end
    txEnable = 1'b0;
    @(negedge clk);
    chk(!spdifOut && !spdifOe, "R1 off quiet", {30'd0, spdifOut, spdifOe}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired, all requirements");
    finishRun();
  end

  initial begin
    rstN = 1'b0; txEnable = 1'b0; bypassSel = 1'b0; validFlag = 1'b0;
    csBytes = 40'h0; usrWrEn = 1'b0; usrWrAddr = 8'd0; usrWrData = 8'd0;
    setInputs(0);
    for (int i = 0; i < 129; i++) msg[i] = 8'((i * 29 + 7) ^ (i >> 2));
    repeat (4) @(negedge clk);
    chk(!spdifOut && !spdifOe, "R1 reset quiet", {30'd0, spdifOut, spdifOe}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!spdifOut && !spdifOe, "R12 disabled oe", {30'd0, spdifOut, spdifOe}, 32'd0);

    // run 1: PCM, validity 0, no message, two block starts, stop mid-frame
    csBytes = 40'hC3_5A_96_0F_E5;
    runHalves(200 * 128 + 37);

    // load the user message while disabled (R11 retention)
    for (int i = 0; i < 129; i++) begin
      @(negedge clk);
      usrWrEn = 1'b1; usrWrAddr = 8'(i); usrWrData = msg[i];
    end
    @(negedge clk);
    usrWrEn = 1'b0;
    msgModel = 1;
    repeat (5) @(negedge clk);

    // run 2: bypass payload, validity 1, message wrap after 516 frames
    bypassSel = 1'b1; validFlag = 1'b1;
    csBytes = 40'h1E_87_F0_3C_2B;
    runHalves(520 * 128);

    // run 3: back to PCM with message loaded, short
    bypassSel = 1'b0; validFlag = 1'b0;
    runHalves(6 * 128);
    finishRun();
  end

endmodule